// File: doc/BRIEF.md
# Background Frequency-Calibration Controller

This block keeps a free-running oscillator centred on a target that a locked reference loop sets. Two slow test clocks arrive from outside: one comes from the oscillator under calibration, and the other from the reference loop. Each measurement window lasts ten reference-clock cycles. During a window the block counts rising edges of both test clocks. At the end of the window it moves an 8-bit DAC code one step toward agreement. The code register drives the fine-tuning control directly, with no filter in between.

The block serves a time-division duplex radio that has two oscillators. While the transmit slot is active, the receive-path oscillator is trimmed. While the receive slot is active, the transmit-path oscillator is trimmed. Calibration therefore runs in the background. In intermittent mode the block stops after a programmed number of windows in each slot and stays idle until the next slot, which saves power and keeps it inside the slot's time budget.

Top module: `freq_cal_ctrl`

## Requirements
- R1: A code update can only happen at the end of a window of 10 reference cycles. Two updates of the same code are at least 10 cycles apart.
- R2: Both test clocks pass through two-flop synchronizers before their rising edges are counted. If the oscillator count is greater than the reference count at the end of a window, the selected code is decremented by exactly one.
- R3: If the oscillator count is lower than the reference count, the selected code is incremented by exactly one.
- R4: If the two counts are equal, the code keeps its value.
- R5: While `pll_lock_i` is low, neither code changes and `busy_o` goes low one cycle later.
- R6: With `slot_tx_i`=1 only `rx_code_o` may update, and with `slot_tx_i`=0 only `tx_code_o` may update. From reset until the first change of `slot_tx_i`, `rx_code_o` is the updated code whatever the slot level.
- R7: Each code saturates at 0 and at 255 and never wraps around.
- R8: With `intermit_en_i`=1, at most `win_limit_i` windows complete per slot, after which `busy_o` is low and both codes hold until the slot changes. With `intermit_en_i`=0, windows run back to back while lock is held.
- R9: If the slot changes or lock is lost partway through a window, that window is discarded: its counts are cleared and no code is updated from it.
- R10: After reset both codes are 128 and `busy_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| osc_tclk_i | input | 1 | Divided test clock from the oscillator under calibration |
| ref_tclk_i | input | 1 | Divided test clock from the reference loop |
| pll_lock_i | input | 1 | Reference loop locked |
| slot_tx_i | input | 1 | 1 = transmit slot, 0 = receive slot |
| intermit_en_i | input | 1 | Enable the window budget per slot |
| win_limit_i | input | 8 | Windows allowed per slot in intermittent mode |
| tx_code_o | output | 8 | DAC code for the transmit-path oscillator |
| rx_code_o | output | 8 | DAC code for the receive-path oscillator |
| busy_o | output | 1 | A measurement window is in progress |

## Verification
The hardest case to reach is a window that is torn apart partway through. Its partial counts must be thrown away, even though the test-clock ratio would have moved the code if the window had finished. The stimulus toggles the slot every six cycles, and in a second pass drops lock two cycles out of every ten. In both passes no window can complete, so any code movement exposes a partial update. Saturation is reached by holding a strong frequency mismatch for more than 128 windows, and the start-up path selection is exercised by releasing reset with the slot at receive.

// File: rtl/freq_cal_pkg.sv
package freq_cal_pkg;
  typedef enum logic {PATH_TX = 1'b0, PATH_RX = 1'b1} cal_path_e;
  typedef enum logic [1:0] {CMP_HOLD = 2'd0, CMP_UP = 2'd1, CMP_DOWN = 2'd2} cal_cmp_e;
endpackage

// File: rtl/cal_sync.sv
module cal_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sh_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      last_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], async_i};
      last_q <= sh_q[STAGES-1];
    end
  end

  assign rise_o = sh_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/cal_edge_cnt.sv
module cal_edge_cnt #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_o <= '0;
    else if (clr_i)                 cnt_o <= '0;
    else if (inc_i && cnt_o != '1)  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/cal_window_seq.sv
module cal_window_seq #(
  parameter int unsigned DIV   = 10,
  parameter int unsigned LIM_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lock_i,
  input  logic             slot_i,
  input  logic             intermit_i,
  input  logic [LIM_W-1:0] limit_i,
  output logic             win_end_o,
  output logic             cnt_clr_o,
  output logic             slot_chg_o,
  output logic             busy_o
);
  localparam int unsigned PH_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV - 1);

  logic             slot_q;
  logic [PH_W-1:0]  phase_q;
  logic [LIM_W-1:0] burst_q;
  logic             spent, active, abort;

  assign slot_chg_o = slot_i != slot_q;
  assign spent      = intermit_i && (burst_q >= limit_i);
  assign active     = lock_i && !spent;
  assign abort      = slot_chg_o || !lock_i;
  assign win_end_o  = active && !abort && (phase_q == PH_LAST);
  assign cnt_clr_o  = !active || abort || win_end_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q  <= 1'b0;
      phase_q <= '0;
      burst_q <= '0;
      busy_o  <= 1'b0;
    end else begin
      slot_q <= slot_i;
      busy_o <= active && !abort;
      if (!active || abort || phase_q == PH_LAST) phase_q <= '0;
      else                                         phase_q <= phase_q + 1'b1;
      if (slot_chg_o)                        burst_q <= '0;
      else if (win_end_o && burst_q != '1)   burst_q <= burst_q + 1'b1;
    end
  end
endmodule

// File: rtl/cal_code_reg.sv
module cal_code_reg
  import freq_cal_pkg::*;
#(
  parameter int unsigned W    = 8,
  parameter int unsigned INIT = 128
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         upd_i,
  input  cal_cmp_e     cmp_i,
  output logic [W-1:0] code_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) code_o <= W'(INIT);
    else if (upd_i) begin
      unique case (cmp_i)
        CMP_UP:   if (code_o != '1) code_o <= code_o + 1'b1;
        CMP_DOWN: if (code_o != '0) code_o <= code_o - 1'b1;
        default:  code_o <= code_o;
      endcase
    end
  end
endmodule

// File: rtl/freq_cal_ctrl.sv
module freq_cal_ctrl
  import freq_cal_pkg::*;
#(
  parameter int unsigned DIV         = 10,
  parameter int unsigned CODE_W      = 8,
  parameter int unsigned CODE_INIT   = 128,
  parameter int unsigned LIM_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              osc_tclk_i,
  input  logic              ref_tclk_i,
  input  logic              pll_lock_i,
  input  logic              slot_tx_i,
  input  logic              intermit_en_i,
  input  logic [LIM_W-1:0]  win_limit_i,
  output logic [CODE_W-1:0] tx_code_o,
  output logic [CODE_W-1:0] rx_code_o,
  output logic              busy_o
);
  localparam int unsigned CNT_W = $clog2(DIV + 1);
  localparam int unsigned N_CH  = 2;   // 0: oscillator, 1: reference

  logic [N_CH-1:0]  tclk, rise;
  logic [CNT_W-1:0] cnt [N_CH];
  logic             win_end, cnt_clr, slot_chg;
  logic             init_q, sel_rx;
  cal_cmp_e         cmp;
  logic [CODE_W-1:0] code [2];

  assign tclk = {ref_tclk_i, osc_tclk_i};

  cal_window_seq #(.DIV(DIV), .LIM_W(LIM_W)) u_seq (
    .clk_i, .rst_ni,
    .lock_i(pll_lock_i), .slot_i(slot_tx_i), .intermit_i(intermit_en_i),
    .limit_i(win_limit_i), .win_end_o(win_end), .cnt_clr_o(cnt_clr),
    .slot_chg_o(slot_chg), .busy_o(busy_o)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    cal_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i, .rst_ni, .async_i(tclk[c]), .rise_o(rise[c])
    );
    cal_edge_cnt #(.W(CNT_W)) u_cnt (
      .clk_i, .rst_ni, .clr_i(cnt_clr), .inc_i(rise[c]), .cnt_o(cnt[c])
    );
  end

  always_comb begin
    if (cnt[0] > cnt[1])      cmp = CMP_DOWN;
    else if (cnt[0] < cnt[1]) cmp = CMP_UP;
    else                      cmp = CMP_HOLD;
  end

  // start-up trims the receive path until the first slot boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       init_q <= 1'b1;
    else if (slot_chg) init_q <= 1'b0;
  end
  assign sel_rx = init_q | slot_tx_i;

  for (genvar p = 0; p < 2; p++) begin : g_path
    logic upd;
    assign upd = win_end && ((p == int'(PATH_RX)) ? sel_rx : !sel_rx);
    cal_code_reg #(.W(CODE_W), .INIT(CODE_INIT)) u_code (
      .clk_i, .rst_ni, .upd_i(upd), .cmp_i(cmp), .code_o(code[p])
    );
  end

  assign tx_code_o = code[PATH_TX];
  assign rx_code_o = code[PATH_RX];
endmodule

// File: rtl/freq_cal_chk.sv
module freq_cal_chk #(
  parameter int unsigned CODE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pll_lock_i,
  input logic              slot_tx_i,
  input logic [CODE_W-1:0] tx_code_o,
  input logic [CODE_W-1:0] rx_code_o,
  input logic              busy_o
);
  logic pv_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pv_q <= 1'b0;
    else         pv_q <= 1'b1;
  end

  AST_RX_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pv_q |-> (rx_code_o == $past(rx_code_o) || rx_code_o == $past(rx_code_o) + 1'b1
              || rx_code_o == $past(rx_code_o) - 1'b1)); // R2
  AST_NO_WRAP_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pv_q && $past(tx_code_o) == '0) |-> tx_code_o <= 1); // R7
  AST_NO_WRAP_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pv_q && $past(rx_code_o) == '1) |-> rx_code_o >= {CODE_W{1'b1}} - 1'b1); // R7
  AST_LOCK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pll_lock_i |=> ($stable(rx_code_o) && $stable(tx_code_o))); // R5
  AST_LOCK_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pll_lock_i |=> !busy_o); // R5
  AST_ONE_PATH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pv_q |-> !(rx_code_o != $past(rx_code_o) && tx_code_o != $past(tx_code_o))); // R6
  AST_SLOT_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pv_q && slot_tx_i != $past(slot_tx_i)) |=> ($stable(rx_code_o) && $stable(tx_code_o))); // R9
endmodule

bind freq_cal_ctrl freq_cal_chk #(.CODE_W(CODE_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pll_lock_i(pll_lock_i), .slot_tx_i(slot_tx_i),
  .tx_code_o(tx_code_o), .rx_code_o(rx_code_o), .busy_o(busy_o)
);

// File: tb/sim_freq_cal_ctrl.sv
module sim_freq_cal_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lock = 1'b0, slot = 1'b0, imode = 1'b0;
  logic [7:0] limit = 8'd3;
  logic osc_clk = 1'b0, ref_clk = 1'b0, ref_tclk;
  logic [7:0] tx_code, rx_code;
  logic busy;
  int osc_half = 1, ref_half = 4, oc = 0, rc = 0;
  bit tie_eq = 1'b0, done = 1'b0;
  int n_chk = 0, n_fail = 0;
  int rx_up = 0, rx_dn = 0, tx_up = 0, tx_dn = 0, bad_step = 0, bad_gap = 0;
  int cyc = 0, last_rx = -100, last_tx = -100;
  logic [7:0] prev_rx = 8'd128, prev_tx = 8'd128;

  always #(CLK_PERIOD/2) clk = ~clk;

  // code-dependent oscillators are replaced by fixed test-clock ratios
  always @(negedge clk) begin
    oc++; if (oc >= osc_half) begin oc = 0; osc_clk = ~osc_clk; end
    rc++; if (rc >= ref_half) begin rc = 0; ref_clk = ~ref_clk; end
  end
  assign ref_tclk = tie_eq ? osc_clk : ref_clk;

  freq_cal_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .osc_tclk_i(osc_clk), .ref_tclk_i(ref_tclk),
    .pll_lock_i(lock), .slot_tx_i(slot), .intermit_en_i(imode), .win_limit_i(limit),
    .tx_code_o(tx_code), .rx_code_o(rx_code), .busy_o(busy)
  );

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (rx_code != prev_rx) begin
        if (rx_code == prev_rx + 8'd1) rx_up++;
        else if (rx_code == prev_rx - 8'd1) rx_dn++;
        else bad_step++;
        if (cyc - last_rx < 10) bad_gap++;
        last_rx = cyc;
      end
      if (tx_code != prev_tx) begin
        if (tx_code == prev_tx + 8'd1) tx_up++;
        else if (tx_code == prev_tx - 8'd1) tx_dn++;
        else bad_step++;
        if (cyc - last_tx < 10) bad_gap++;
        last_tx = cyc;
      end
    end
    prev_rx = rx_code;
    prev_tx = tx_code;
  end

  task automatic clr_stats();
    rx_up = 0; rx_dn = 0; tx_up = 0; tx_dn = 0;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(5);
    chk(rx_code == 8'd128, "R10 rx reset", rx_code, 128);
    chk(tx_code == 8'd128, "R10 tx reset", tx_code, 128);
    chk(busy == 1'b0, "R10 busy reset", busy, 0);

    wait_cyc(100);
    chk(rx_code == 8'd128 && tx_code == 8'd128, "R5 no lock hold", rx_code, 128);
    chk(busy == 1'b0, "R5 busy without lock", busy, 0);

    // start-up with slot at receive: rx path is trimmed (R6), oscillator fast
    clr_stats();
    lock = 1'b1;
    wait_cyc(300);
    chk(rx_dn >= 27 && rx_dn <= 30, "R1 R2 rx decrements per window", rx_dn, 30);
    chk(rx_up == 0, "R2 no wrong direction", rx_up, 0);
    chk(tx_up + tx_dn == 0, "R6 tx idle at start-up", tx_up + tx_dn, 0);
    chk(busy == 1'b1, "R8 continuous busy", busy, 1);
    chk(bad_gap == 0, "R1 update spacing", bad_gap, 0);

    wait_cyc(2000);
    chk(rx_code == 8'd0, "R7 rx floor", rx_code, 0);
    chk(bad_step == 0, "R7 no wrap", bad_step, 0);

    slot = 1'b1; wait_cyc(20);
    slot = 1'b0; osc_half = 4; ref_half = 1;
    clr_stats();
    wait_cyc(3000);
    chk(tx_code == 8'd255, "R3 R7 tx ceiling", tx_code, 255);
    chk(tx_dn == 0, "R3 tx only up", tx_dn, 0);
    chk(rx_up + rx_dn == 0, "R6 rx idle in receive slot", rx_up + rx_dn, 0);
    chk(bad_step == 0, "R7 no wrap at top", bad_step, 0);

    slot = 1'b1;
    clr_stats();
    wait_cyc(300);
    chk(rx_up >= 27 && rx_up <= 30, "R3 R6 rx up in transmit slot", rx_up, 30);
    chk(tx_up + tx_dn == 0, "R6 tx idle in transmit slot", tx_up + tx_dn, 0);

    tie_eq = 1'b1;
    wait_cyc(20);
    clr_stats();
    wait_cyc(200);
    chk(rx_up + rx_dn == 0, "R4 equal counts hold", rx_up + rx_dn, 0);

    tie_eq = 1'b0; osc_half = 1; ref_half = 4;
    clr_stats();
    for (int i = 0; i < 100; i++) begin
      slot = ~slot; wait_cyc(6);
    end
    chk(rx_up + rx_dn + tx_up + tx_dn == 0, "R9 slot abort discards",
        rx_up + rx_dn + tx_up + tx_dn, 0);

    for (int i = 0; i < 60; i++) begin
      lock = 1'b0; wait_cyc(2);
      lock = 1'b1; wait_cyc(8);
    end
    chk(rx_up + rx_dn + tx_up + tx_dn == 0, "R9 lock abort discards",
        rx_up + rx_dn + tx_up + tx_dn, 0);
    lock = 1'b0; wait_cyc(2);
    chk(busy == 1'b0, "R5 busy falls on lock loss", busy, 0);

    imode = 1'b1; limit = 8'd3; lock = 1'b1;
    slot = ~slot;
    clr_stats();
    wait_cyc(400);
    chk(rx_up + rx_dn + tx_up + tx_dn == 3, "R8 window budget",
        rx_up + rx_dn + tx_up + tx_dn, 3);
    chk(busy == 1'b0, "R8 idle after budget", busy, 0);

    limit = 8'd0;
    slot = ~slot;
    clr_stats();
    wait_cyc(200);
    chk(rx_up + rx_dn + tx_up + tx_dn == 0, "R8 zero budget",
        rx_up + rx_dn + tx_up + tx_dn, 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule